// File: doc/BRIEF.md
# SDRAM Write Access Sequencer

This block turns one write request at a time from an internal requester into the command sequence an SDRAM device expects. It opens the target bank and row, waits a programmable activate-to-write delay, and issues a write that carries the bank and column. The write data goes out on the data pins and the byte lanes that must not change are masked. The block then waits a programmable write recovery time, closes the row with a single-bank precharge, waits the precharge time and acknowledges the requester. Between commands the command pins carry NOP.

The data bus is either 32 bits wide or, when the narrow configuration bit is set, 16 bits wide. In narrow mode each write is a two-beat burst on an aligned column pair: the low halfword goes first and the high halfword follows on the next cycle. A 16-bit request in narrow mode fully masks the beat it does not use. Auto-precharge is never requested.

The requester holds `req_valid` and its fields until it sees `req_ack`. The configuration inputs must stay stable while a sequence is in flight.

Top module: `sdram_wr_seq`

## Requirements
- R1: During and after reset, before any request, the command pins encode NOP, `sd_dq_oe` is 0, `sd_dq` is 0, `sd_dqm` is all ones, `sd_ba`/`sd_a` are 0 and `req_ack` is 0.
- R2: The first command of each access is ACTIVATE, issued in the cycle after the edge on which an idle block sees `req_valid`. It carries the bank on `sd_ba` and the row on `sd_a`. With the bus wide, column = addr[9:2], row = addr[21:10] and bank = addr[23:22]. With the bus narrow, row = addr[20:9] and bank = addr[22:21].
- R3: WRITE follows ACTIVATE after exactly `cfg_trcd`+1 cycles, with NOP in between. It carries the same bank and the column on `sd_a`, and `sd_a[10]` is 0.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as ACTIVATE 0011, WRITE 0100, PRECHARGE 0010 and NOP 0111. `sd_dq_oe` is 1 only on data beats, and `sd_dq` is 0 and `sd_dqm` is all ones whenever `sd_dq_oe` is 0.
- R5: With `cfg_narrow`=0, each access has a single data beat, in the WRITE cycle, with `sd_dq` = write data and `sd_dqm` = inverted byte enables (1 = masked). `req_size32` is ignored.
- R6: With `cfg_narrow`=1 and `req_size32`=1, the write uses the even column {addr[8:2],0}. Beat one (the WRITE cycle) carries data[15:0] with mask ~be[1:0]. Beat two (the next cycle, command NOP) carries data[31:16] with mask ~be[3:2]. `sd_dq[31:16]` is 0 and `sd_dqm[3:2]` is 11 on both beats.
- R7: With `cfg_narrow`=1 and `req_size32`=0, both beats still occur. If addr[1]=0, beat two is fully masked (`sd_dqm`=4'hF). If addr[1]=1, beat one is fully masked.
- R8: PRECHARGE follows the last data beat after exactly `cfg_twr`+1 cycles. It carries the access's bank, with `sd_a` = 0 so that only one bank closes.
- R9: `req_ack` is 1 for exactly one cycle, `cfg_trp`+1 cycles after PRECHARGE.
- R10: A request is accepted only while the block is idle. Address, data, byte enables and size are captured at acceptance, and later changes to them have no effect on the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request, held until acknowledged |
| req_addr | input | 24 | Byte address {bank,row,column,byte} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, 1 = write the byte |
| req_size32 | input | 1 | 1 = 32-bit access (used in narrow mode) |
| req_ack | output | 1 | One-cycle completion pulse |
| cfg_narrow | input | 1 | 1 = 16-bit SDRAM data bus |
| cfg_trcd | input | 4 | Activate-to-write delay minus one |
| cfg_twr | input | 4 | Write recovery minus one |
| cfg_trp | input | 4 | Precharge time minus one |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column address |
| sd_dq | output | 32 | Write data |
| sd_dq_oe | output | 1 | Data pin drive enable |
| sd_dqm | output | 4 | Byte mask, 1 = masked |

## Verification
A wrong state or a wrong timer value shows up on the command pins within one cycle as an early or late WRITE, PRECHARGE or acknowledge. The reference model compares every pin on every clock, so an off-by-one in any delay field fails in the first cycle where the pins differ. Errors in field capture or lane steering appear as wrong bank, row, column or mask values on the ACTIVATE, WRITE and beat-two cycles. A sequencer that reaccepts the request in flight shows an extra ACTIVATE right after the acknowledge.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    // Command encoding on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_BEAT2,
        ST_WR,
        ST_RP
    } seq_st_e;

endpackage

// File: rtl/sdram_wr_addr_map.sv
module sdram_wr_addr_map #(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // Wide bus: 4-byte words; narrow bus: 2-byte words
    localparam int W_COL = 2;
    localparam int W_ROW = W_COL + COL_W;
    localparam int W_BNK = W_ROW + ROW_W;
    localparam int N_ROW = 1 + COL_W;
    localparam int N_BNK = N_ROW + ROW_W;

    logic unused_lsb;
    assign unused_lsb = addr[0];

    always_comb begin
        if (narrow) begin
            col  = {addr[COL_W:2], 1'b0};
            row  = addr[N_ROW +: ROW_W];
            bank = addr[N_BNK +: BANK_W];
        end else begin
            col  = addr[W_COL +: COL_W];
            row  = addr[W_ROW +: ROW_W];
            bank = addr[W_BNK +: BANK_W];
        end
    end

endmodule

// File: rtl/sdram_wr_beats.sv
module sdram_wr_beats #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    input  logic                size32,
    input  logic                narrow,
    input  logic                hsel,
    output logic [DATA_W-1:0]   b0_dq,
    output logic [DATA_W/8-1:0] b0_dqm,
    output logic [DATA_W-1:0]   b1_dq,
    output logic [DATA_W/8-1:0] b1_dqm,
    output logic                two_beat
);
    localparam int BE_W = DATA_W / 8;
    localparam int HALF = DATA_W / 2;
    localparam int HBE  = BE_W / 2;

    logic lo_en;
    logic hi_en;

    assign lo_en = size32 | ~hsel;
    assign hi_en = size32 | hsel;

    always_comb begin
        if (narrow) begin
            two_beat = 1'b1;
            b0_dq    = {{HALF{1'b0}}, wdata[HALF-1:0]};
            b1_dq    = {{HALF{1'b0}}, wdata[DATA_W-1:HALF]};
            b0_dqm   = {{HBE{1'b1}}, lo_en ? ~be[HBE-1:0]    : {HBE{1'b1}}};
            b1_dqm   = {{HBE{1'b1}}, hi_en ? ~be[BE_W-1:HBE] : {HBE{1'b1}}};
        end else begin
            two_beat = 1'b0;
            b0_dq    = wdata;
            b0_dqm   = ~be;
            b1_dq    = '0;
            b1_dqm   = '1;
        end
    end

endmodule

// File: rtl/sdram_wr_timer.sv
module sdram_wr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int TMR_W  = 4,
    localparam int BE_W   = DATA_W / 8,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_size32,
    output logic              req_ack,
    input  logic              cfg_narrow,
    input  logic [TMR_W-1:0]  cfg_trcd,
    input  logic [TMR_W-1:0]  cfg_twr,
    input  logic [TMR_W-1:0]  cfg_trp,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [DATA_W-1:0] sd_dq,
    output logic              sd_dq_oe,
    output logic [BE_W-1:0]   sd_dqm
);
    localparam int AP_BIT = 10;

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic              s32;
        sd_cmd_e           cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic              oe;
        logic [DATA_W-1:0] dq;
        logic [BE_W-1:0]   dqm;
        logic              ack;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] map_addr;
    logic [BANK_W-1:0] map_bank;
    logic [ROW_W-1:0]  map_row;
    logic [COL_W-1:0]  map_col;
    logic [ROW_W-1:0]  col_bus;
    logic [DATA_W-1:0] b0_dq, b1_dq;
    logic [BE_W-1:0]   b0_dqm, b1_dqm;
    logic              two_beat;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;

    assign map_addr = (r_q.st == ST_IDLE) ? req_addr : r_q.addr;

    sdram_wr_addr_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_map (
        .addr   (map_addr),
        .narrow (cfg_narrow),
        .bank   (map_bank),
        .row    (map_row),
        .col    (map_col)
    );

    sdram_wr_beats #(
        .DATA_W (DATA_W)
    ) u_beats (
        .wdata    (r_q.data),
        .be       (r_q.be),
        .size32   (r_q.s32),
        .narrow   (cfg_narrow),
        .hsel     (r_q.addr[1]),
        .b0_dq    (b0_dq),
        .b0_dqm   (b0_dqm),
        .b1_dq    (b1_dq),
        .b1_dqm   (b1_dqm),
        .two_beat (two_beat)
    );

    sdram_wr_timer #(
        .W (TMR_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Column on the address pins, auto-precharge bit held low
    always_comb begin
        col_bus              = '0;
        col_bus[COL_W-1:0]   = map_col;
        col_bus[AP_BIT]      = 1'b0;
    end

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.ba   = '0;
        r_d.a    = '0;
        r_d.oe   = 1'b0;
        r_d.dq   = '0;
        r_d.dqm  = '1;
        r_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.data = req_wdata;
                    r_d.be   = req_be;
                    r_d.s32  = req_size32;
                    r_d.cmd  = CMD_ACT;
                    r_d.ba   = map_bank;
                    r_d.a    = map_row;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_trcd;
                    r_d.st   = ST_RCD;
                end
            end
            ST_RCD: begin
                if (tmr_done) begin
                    r_d.cmd = CMD_WRITE;
                    r_d.ba  = map_bank;
                    r_d.a   = col_bus;
                    r_d.oe  = 1'b1;
                    r_d.dq  = b0_dq;
                    r_d.dqm = b0_dqm;
                    if (two_beat) begin
                        r_d.st = ST_BEAT2;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = cfg_twr;
                        r_d.st   = ST_WR;
                    end
                end
            end
            ST_BEAT2: begin
                r_d.oe   = 1'b1;
                r_d.dq   = b1_dq;
                r_d.dqm  = b1_dqm;
                tmr_load = 1'b1;
                tmr_val  = cfg_twr;
                r_d.st   = ST_WR;
            end
            ST_WR: begin
                if (tmr_done) begin
                    r_d.cmd  = CMD_PRE;
                    r_d.ba   = map_bank;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_trp;
                    r_d.st   = ST_RP;
                end
            end
            ST_RP: begin
                if (tmr_done) begin
                    r_d.ack = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cmd  <= CMD_NOP;
            r_q.dqm  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_cs_n  = r_q.cmd[3];
    assign sd_ras_n = r_q.cmd[2];
    assign sd_cas_n = r_q.cmd[1];
    assign sd_we_n  = r_q.cmd[0];
    assign sd_ba    = r_q.ba;
    assign sd_a     = r_q.a;
    assign sd_dq    = r_q.dq;
    assign sd_dq_oe = r_q.oe;
    assign sd_dqm   = r_q.dqm;
    assign req_ack  = r_q.ack;

endmodule

// File: rtl/sdram_wr_seq_chk.sv
module sdram_wr_seq_chk #(
    parameter int ROW_W = 12,
    parameter int BE_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_narrow,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_a,
    input logic             sd_dq_oe,
    input logic [BE_W-1:0]  sd_dqm,
    input logic             req_ack
);
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R9

    AST_WRITE_NO_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0100) |-> (sd_a[10] == 1'b0)); // R3

    AST_WRITE_DRIVES_DQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0100) |-> sd_dq_oe); // R4

    AST_ROW_CMD_NO_DQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0011 || cmd == 4'b0010) |-> !sd_dq_oe); // R4

    AST_WIDE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_narrow && $past(cmd) == 4'b0100) |-> !sd_dq_oe); // R5

    AST_NARROW_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_narrow && $past(cmd) == 4'b0100) |-> sd_dq_oe); // R6

    AST_NARROW_UPPER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_narrow && sd_dq_oe) |-> (sd_dqm[BE_W-1:BE_W/2] == '1)); // R6

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
    .ROW_W (ROW_W),
    .BE_W  (BE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_narrow (cfg_narrow),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_a       (sd_a),
    .sd_dq_oe   (sd_dq_oe),
    .sd_dqm     (sd_dqm),
    .req_ack    (req_ack)
);

// File: tb/sdram_wr_seq_bench.sv
module sdram_wr_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_size32 = 1'b0;
    logic        req_ack;
    logic        cfg_narrow = 1'b0;
    logic [3:0]  cfg_trcd = '0, cfg_twr = '0, cfg_trp = '0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_a;
    logic [31:0] sd_dq;
    logic        sd_dq_oe;
    logic [3:0]  sd_dqm;

    always #10 clk = ~clk;

    sdram_wr_seq u_sdram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_size32(req_size32),
        .req_ack(req_ack), .cfg_narrow(cfg_narrow), .cfg_trcd(cfg_trcd),
        .cfg_twr(cfg_twr), .cfg_trp(cfg_trp), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe),
        .sd_dqm(sd_dqm)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] a;
        logic        oe;
        logic [31:0] dq;
        logic [3:0]  dqm;
        logic        ack;
    } obs_t;

    localparam logic [3:0] C_ACT = 4'b0011, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_NOP = 4'b0111;

    obs_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    function automatic obs_t mk(logic [3:0] c, logic [1:0] b, logic [11:0] a,
                                logic oe, logic [31:0] dq, logic [3:0] m, logic ack);
        obs_t o;
        o.cmd = c; o.ba = b; o.a = a; o.oe = oe; o.dq = dq; o.dqm = m; o.ack = ack;
        return o;
    endfunction

    function automatic obs_t observe();
        return mk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, sd_ba, sd_a,
                  sd_dq_oe, sd_dq, sd_dqm, req_ack);
    endfunction

    function automatic void push(obs_t o, string tag, string ovr);
        exp_q.push_back(o);
        tag_q.push_back(ovr != "" ? ovr : tag);
    endfunction

    function automatic void check(obs_t act, obs_t exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cmd/ba/a/oe/dq/dqm/ack)", tag, act, exp);
        end
    endfunction

    // Reference model: expected pin values, one entry per cycle after acceptance
    function automatic void build(logic nar, int t1, int t2, int t3, logic [23:0] ad,
                                  logic [31:0] d, logic [3:0] be, logic s32, string ovr);
        logic [1:0]  bank;
        logic [11:0] row, col;
        logic        lo, hi;
        if (!nar) begin
            col  = 12'((ad >> 2) % 256);
            row  = 12'((ad >> 10) % 4096);
            bank = 2'((ad >> 22) % 4);
        end else begin
            col  = 12'(((ad >> 2) % 128) * 2);
            row  = 12'((ad >> 9) % 4096);
            bank = 2'((ad >> 21) % 4);
        end
        push(mk(C_ACT, bank, row, 0, 0, 4'hF, 0), "R2", ovr);
        for (int i = 0; i < t1; i++) push(mk(C_NOP, 0, 0, 0, 0, 4'hF, 0), "R3", ovr);
        if (!nar) begin
            push(mk(C_WR, bank, col, 1, d, ~be, 0), "R5", ovr);
        end else begin
            lo = s32 || !ad[1];
            hi = s32 || ad[1];
            push(mk(C_WR, bank, col, 1, {16'h0, d[15:0]},
                    {2'b11, lo ? ~be[1:0] : 2'b11}, 0), s32 ? "R6" : "R7", ovr);
            push(mk(C_NOP, 0, 0, 1, {16'h0, d[31:16]},
                    {2'b11, hi ? ~be[3:2] : 2'b11}, 0), s32 ? "R6" : "R7", ovr);
        end
        for (int i = 0; i < t2; i++) push(mk(C_NOP, 0, 0, 0, 0, 4'hF, 0), "R8", ovr);
        push(mk(C_PRE, bank, 0, 0, 0, 4'hF, 0), "R8", ovr);
        for (int i = 0; i < t3; i++) push(mk(C_NOP, 0, 0, 0, 0, 4'hF, 0), "R9", ovr);
        push(mk(C_NOP, 0, 0, 0, 0, 4'hF, 1), "R9", ovr);
    endfunction

    // Called at a negedge with the block idle
    task automatic run(logic nar, int t1, int t2, int t3, logic [23:0] ad,
                       logic [31:0] d, logic [3:0] be, logic s32, string ovr, bit mutate);
        obs_t  e;
        string t;
        cfg_narrow = nar;
        cfg_trcd = 4'(t1); cfg_twr = 4'(t2); cfg_trp = 4'(t3);
        req_addr = ad; req_wdata = d; req_be = be; req_size32 = s32;
        req_valid = 1'b1;
        build(nar, t1, t2, t3, ad, d, be, s32, ovr);
        while (exp_q.size() > 0) begin
            @(negedge clk);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(observe(), e, t);
            if (mutate) begin
                // R10: fields change while the access is in flight
                req_addr  = ~ad;
                req_wdata = ~d;
                req_be    = ~be;
                req_size32 = ~s32;
            end
            if (e.ack) req_valid = 1'b0;
        end
        // Idle after completion: no new access, no data drive
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(observe(), mk(C_NOP, 0, 0, 0, 0, 4'hF, 0), mutate ? "R10" : "R4");
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(observe(), mk(C_NOP, 0, 0, 0, 0, 4'hF, 0), "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(observe(), mk(C_NOP, 0, 0, 0, 0, 4'hF, 0), "R1");
        end
        // Wide bus, various masks and timings
        run(0, 1, 1, 1, 24'h5A_B3C4, 32'hDEAD_BEEF, 4'b1111, 1, "", 0);
        run(0, 0, 0, 0, 24'hC0_0FFC, 32'h1234_5678, 4'b0101, 0, "", 0);
        run(0, 3, 2, 4, 24'h3F_FFF8, 32'hA5A5_0F0F, 4'b1000, 0, "", 0);
        // Narrow bus, 32-bit burst of two
        run(1, 2, 1, 0, 24'h12_3456, 32'hCAFE_F00D, 4'b1111, 1, "", 0);
        run(1, 0, 3, 2, 24'h7F_FFFE, 32'h8765_4321, 4'b0110, 1, "", 0);
        // Narrow bus, 16-bit writes in each half
        run(1, 1, 0, 1, 24'h40_1000, 32'h0000_1111, 4'b0011, 0, "", 0);
        run(1, 1, 2, 0, 24'h40_1002, 32'h2222_0000, 4'b0100, 0, "", 0);
        // Long timings at field maximum
        run(0, 15, 15, 15, 24'h81_2344, 32'h0BAD_CAFE, 4'b0010, 0, "", 0);
        // Request fields change mid-sequence (R10)
        run(0, 2, 1, 1, 24'h25_5554, 32'h600D_D00D, 4'b1101, 0, "R10", 1);
        run(1, 1, 1, 1, 24'h66_0000, 32'hFACE_B00C, 4'b1011, 1, "R10", 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule